// File: doc/BRIEF.md
# Linked-List DMA Chain Walker

This block is one channel mode of a DMA engine. It follows a chain of packets held in main RAM and hands every payload word of every packet to a peripheral write port. Software gives it the address of the first packet and raises an enable bit. The walker then reads each packet's header word. The top eight bits of the header are the number of payload words that follow. The low 24 bits are the address of the next packet. The walker streams the payload, jumps to the next packet and repeats. It stops when the next address is the all-ones terminator 0xFFFFFF.

Reads from RAM use a request/ready handshake, and the RAM address is the 24-bit working address reduced to a word-aligned 21-bit window. Payload words leave on a valid/ready port. A slow peripheral therefore holds the walker back without dropping any word. The walk also stops on any header or payload address with bit 23 set. In that case the walker drops its active flag and gives a one-cycle error pulse. A normal end gives a one-cycle completion pulse instead.

The controller is a single state machine with six named states:
- IDLE waits for a start.
- HDR_FETCH reads the header.
- HDR_COST spends the fixed header overhead.
- PAY_FETCH reads one payload word.
- PAY_PUSH offers that word to the peripheral.
- LINK decides between ending and fetching the next header.

The transitions are as follows:
- start moves IDLE to HDR_FETCH.
- header accepted moves HDR_FETCH to HDR_COST.
- cost spent moves HDR_COST to PAY_FETCH, or to LINK when the packet is empty.
- word read moves PAY_FETCH to PAY_PUSH.
- word taken moves PAY_PUSH back to PAY_FETCH, or to LINK after the last word.
- follow moves LINK to HDR_FETCH.
- chain end moves LINK to IDLE.
- bad address moves HDR_FETCH or PAY_FETCH to IDLE.

Top module: `ll_dma_walker`

## Requirements
- R1: A walk starts only when enable_i goes from 0 to 1 while the walker is idle. active_o is 1 in the cycle after that edge. An edge seen while busy, and an enable held high after a walk ends, start nothing.
- R2: The header of each packet is read at the packet address ANDed with 0x1FFFFC (mem_addr_o carries bits 20..0 of that value).
- R3: Header bits 31..24 are the payload word count and header bits 23..0 are the next packet address.
- R4: A header count of 0 means the packet has no payload: no peripheral word is produced for it and the next header is fetched.
- R5: Payload words are read at header address +4, +8, ... in order and forwarded to per_data_o in the same order.
- R6: While per_valid_o is 1 and per_ready_i is 0, per_valid_o stays 1 and per_data_o stays unchanged in the next cycle. No word is lost or repeated.
- R7: With an immediately ready RAM, the first payload read is accepted 16 cycles after its header read is accepted when the count is nonzero. When the count is zero, the next header read is accepted 12 cycles after the header read. These figures come from 15 and 10 overhead cycles respectively.
- R8: When a packet finishes and its next address is 0xFFFFFF, done_o pulses for exactly one cycle and active_o is 0 in that cycle.
- R9: A header or payload address with bit 23 set (other than the terminator) is never sent to RAM. err_o pulses for one cycle with active_o 0, and no completion pulse follows.
- R10: done_o and err_o are never 1 in the same cycle.
- R11: While mem_req_o is 1 and mem_ready_i is 0, the request and mem_addr_o stay unchanged in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| base_addr_i | input | 24 | Address of the first packet, captured at start |
| enable_i | input | 1 | Channel enable; a rising edge while idle starts a walk |
| mem_req_o | output | 1 | RAM read request |
| mem_addr_o | output | 21 | Word-aligned RAM byte address |
| mem_ready_i | input | 1 | RAM accepts the request; read data valid this cycle |
| mem_rdata_i | input | 32 | RAM read data |
| per_valid_o | output | 1 | Payload word available to the peripheral |
| per_data_o | output | 32 | Payload word |
| per_ready_i | input | 1 | Peripheral takes the word |
| active_o | output | 1 | Walk in progress (enable/trigger state of the channel) |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | One-cycle bad-address pulse |

## Verification
The embedded properties check several handshake rules on every cycle. They cover the stall behaviour of both handshakes, and the fact that a walk becomes active only after an accepted start. They also check that the two end pulses are exclusive and land with the walker idle, and that the overhead counter never runs from zero. The bench scenarios cover what only a comparison against prepared RAM contents can show. That means the exact addresses read, the header field split, and the payload order under random stalls. It also means the 16- and 12-cycle header spacing, an empty packet, and an edge ignored while busy. A bad pointer that must never reach the RAM port is checked the same way.

// File: rtl/ll_dma_pkg.sv
package ll_dma_pkg;

    typedef enum logic [2:0] {
        WS_IDLE      = 3'd0,
        WS_HDR_FETCH = 3'd1,
        WS_HDR_COST  = 3'd2,
        WS_PAY_FETCH = 3'd3,
        WS_PAY_PUSH  = 3'd4,
        WS_LINK      = 3'd5
    } walk_state_e;

endpackage

// File: rtl/ll_start_detect.sv
module ll_start_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic enable_i,
    input  logic idle_i,
    output logic start_o
);

    logic enable_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            enable_q <= 1'b0;
        end else begin
            enable_q <= enable_i;
        end
    end

    // Only a fresh 0->1 edge seen while nothing is running counts.
    assign start_o = enable_i && !enable_q && idle_i;

endmodule

// File: rtl/ll_cost_timer.sv
module ll_cost_timer #(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic [CW-1:0] load_val_i,
    input  logic          run_i,
    output logic          last_o
);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= load_val_i;
        end else if (run_i && (cnt_q != '0)) begin
            cnt_q <= cnt_q - CW'(1);
        end
    end

    assign last_o = run_i && (cnt_q == CW'(1));

    // R7: the overhead window never runs on an exhausted counter
    p_cost_live_r7: assert property (@(posedge clk) disable iff (!rst_n)
        run_i |-> (cnt_q != '0));

endmodule

// File: rtl/ll_walk_fsm.sv
module ll_walk_fsm
    import ll_dma_pkg::*;
#(
    parameter int AW      = 24,
    parameter int MAW     = 21,
    parameter int DW      = 32,
    parameter int LW      = 8,
    parameter int COST_NZ = 15,
    parameter int COST_Z  = 10,
    parameter int CW      = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start_i,
    input  logic [AW-1:0]  base_addr_i,
    output logic           mem_req_o,
    output logic [MAW-1:0] mem_addr_o,
    input  logic           mem_ready_i,
    input  logic [DW-1:0]  mem_rdata_i,
    output logic           per_valid_o,
    output logic [DW-1:0]  per_data_o,
    input  logic           per_ready_i,
    output logic           cost_load_o,
    output logic [CW-1:0]  cost_val_o,
    output logic           cost_run_o,
    input  logic           cost_last_i,
    output logic           idle_o,
    output logic           active_o,
    output logic           done_o,
    output logic           err_o
);

    localparam logic [AW-1:0] SENTINEL = {AW{1'b1}};
    localparam int            BADBIT   = AW - 1;

    walk_state_e   state_q, state_d;
    logic [AW-1:0] cur_q;
    logic [AW-1:0] link_q;
    logic [LW-1:0] len_q;
    logic [DW-1:0] data_q;
    logic          done_q, err_q;

    logic          bad_addr;
    logic          at_end;
    logic [LW-1:0] hdr_len;

    assign bad_addr = cur_q[BADBIT];
    assign at_end   = (link_q == SENTINEL);
    assign hdr_len  = mem_rdata_i[DW-1 -: LW];

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= WS_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            WS_IDLE: begin
                if (start_i) state_d = WS_HDR_FETCH;
            end
            WS_HDR_FETCH: begin
                if (bad_addr)         state_d = WS_IDLE;
                else if (mem_ready_i) state_d = WS_HDR_COST;
            end
            WS_HDR_COST: begin
                if (cost_last_i) state_d = (len_q == '0) ? WS_LINK : WS_PAY_FETCH;
            end
            WS_PAY_FETCH: begin
                if (bad_addr)         state_d = WS_IDLE;
                else if (mem_ready_i) state_d = WS_PAY_PUSH;
            end
            WS_PAY_PUSH: begin
                if (per_ready_i) state_d = (len_q == LW'(1)) ? WS_LINK : WS_PAY_FETCH;
            end
            WS_LINK: begin
                state_d = at_end ? WS_IDLE : WS_HDR_FETCH;
            end
            default: state_d = WS_IDLE;
        endcase
    end

    // Datapath and registered pulses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q  <= '0;
            link_q <= '0;
            len_q  <= '0;
            data_q <= '0;
            done_q <= 1'b0;
            err_q  <= 1'b0;
        end else begin
            done_q <= (state_q == WS_LINK) && at_end;
            err_q  <= ((state_q == WS_HDR_FETCH) || (state_q == WS_PAY_FETCH)) && bad_addr;
            unique case (state_q)
                WS_IDLE: begin
                    if (start_i) cur_q <= base_addr_i;
                end
                WS_HDR_FETCH: begin
                    if (!bad_addr && mem_ready_i) begin
                        len_q  <= hdr_len;
                        link_q <= mem_rdata_i[AW-1:0];
                        cur_q  <= cur_q + AW'(4);
                    end
                end
                WS_PAY_FETCH: begin
                    if (!bad_addr && mem_ready_i) data_q <= mem_rdata_i;
                end
                WS_PAY_PUSH: begin
                    if (per_ready_i) begin
                        cur_q <= cur_q + AW'(4);
                        len_q <= len_q - LW'(1);
                    end
                end
                WS_LINK: begin
                    if (!at_end) cur_q <= link_q;
                end
                default: ;
            endcase
        end
    end

    // Outputs
    always_comb begin
        mem_req_o   = ((state_q == WS_HDR_FETCH) || (state_q == WS_PAY_FETCH)) && !bad_addr;
        mem_addr_o  = {cur_q[MAW-1:2], 2'b00};
        per_valid_o = (state_q == WS_PAY_PUSH);
        per_data_o  = data_q;
        cost_load_o = (state_q == WS_HDR_FETCH) && !bad_addr && mem_ready_i;
        cost_val_o  = (hdr_len != '0) ? CW'(COST_NZ) : CW'(COST_Z);
        cost_run_o  = (state_q == WS_HDR_COST);
        idle_o      = (state_q == WS_IDLE);
        active_o    = (state_q != WS_IDLE);
        done_o      = done_q;
        err_o       = err_q;
    end

    // R1: leaving idle only ever follows an accepted start
    p_start_edge_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(state_q != WS_IDLE) |-> $past(start_i));

    // R1: nothing is requested or offered while idle
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == WS_IDLE) |-> (!mem_req_o && !per_valid_o));

    // R6: a stalled payload word is held
    p_per_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (per_valid_o && !per_ready_i) |=> (per_valid_o && $stable(per_data_o)));

    // R11: a stalled RAM request is held
    p_mem_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && !mem_ready_i) |=> (mem_req_o && $stable(mem_addr_o)));

    // R8: completion pulse lasts one cycle and the walker is idle
    p_done_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!active_o ##1 !done_o));

    // R9: error pulse lands with the walker idle
    p_err_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> !active_o);

    // R10: the two end pulses are exclusive
    p_end_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_o && err_o));

endmodule

// File: rtl/ll_dma_walker.sv
module ll_dma_walker #(
    parameter int AW      = 24,
    parameter int MAW     = 21,
    parameter int LW      = 8,
    parameter int COST_NZ = 15,
    parameter int COST_Z  = 10
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [AW-1:0]   base_addr_i,
    input  logic            enable_i,
    output logic            mem_req_o,
    output logic [MAW-1:0]  mem_addr_o,
    input  logic            mem_ready_i,
    input  logic [AW+LW-1:0] mem_rdata_i,
    output logic            per_valid_o,
    output logic [AW+LW-1:0] per_data_o,
    input  logic            per_ready_i,
    output logic            active_o,
    output logic            done_o,
    output logic            err_o
);

    localparam int DW       = AW + LW;
    localparam int COST_MAX = (COST_NZ > COST_Z) ? COST_NZ : COST_Z;
    localparam int CW       = $clog2(COST_MAX + 1);

    logic          start;
    logic          idle;
    logic          cost_load;
    logic [CW-1:0] cost_val;
    logic          cost_run;
    logic          cost_last;

    ll_start_detect u_start (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable_i (enable_i),
        .idle_i   (idle),
        .start_o  (start)
    );

    ll_cost_timer #(.CW(CW)) u_cost (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (cost_load),
        .load_val_i (cost_val),
        .run_i      (cost_run),
        .last_o     (cost_last)
    );

    ll_walk_fsm #(
        .AW      (AW),
        .MAW     (MAW),
        .DW      (DW),
        .LW      (LW),
        .COST_NZ (COST_NZ),
        .COST_Z  (COST_Z),
        .CW      (CW)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start),
        .base_addr_i (base_addr_i),
        .mem_req_o   (mem_req_o),
        .mem_addr_o  (mem_addr_o),
        .mem_ready_i (mem_ready_i),
        .mem_rdata_i (mem_rdata_i),
        .per_valid_o (per_valid_o),
        .per_data_o  (per_data_o),
        .per_ready_i (per_ready_i),
        .cost_load_o (cost_load),
        .cost_val_o  (cost_val),
        .cost_run_o  (cost_run),
        .cost_last_i (cost_last),
        .idle_o      (idle),
        .active_o    (active_o),
        .done_o      (done_o),
        .err_o       (err_o)
    );

endmodule

// File: tb/sim_ll_dma_walker.sv
`timescale 1ns/1ps
module sim_ll_dma_walker;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [23:0] base_addr;
    logic        en;
    logic        mem_req;
    logic [20:0] mem_addr;
    logic        mem_ready;
    logic [31:0] mem_rdata;
    logic        per_valid;
    logic [31:0] per_data;
    logic        per_ready;
    logic        active, done, err;

    logic [31:0] bmem [0:127];
    logic        mem_stall;
    logic        rand_mode;
    logic        per_rdy_fixed;
    logic [7:0]  lfsr;

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;

    logic [20:0] acc_addr [0:31];
    int          acc_cyc  [0:31];
    int          n_acc;
    logic [31:0] pw       [0:31];
    int          n_per;
    int          n_done;
    int          n_err;

    always #2.5 clk = ~clk;

    assign mem_ready = mem_req && !mem_stall && !(rand_mode && lfsr[1]);
    assign mem_rdata = bmem[mem_addr[8:2]];
    assign per_ready = rand_mode ? lfsr[0] : per_rdy_fixed;

    ll_dma_walker u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .base_addr_i (base_addr),
        .enable_i    (en),
        .mem_req_o   (mem_req),
        .mem_addr_o  (mem_addr),
        .mem_ready_i (mem_ready),
        .mem_rdata_i (mem_rdata),
        .per_valid_o (per_valid),
        .per_data_o  (per_data),
        .per_ready_i (per_ready),
        .active_o    (active),
        .done_o      (done),
        .err_o       (err)
    );

    always @(negedge clk) lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};

    always @(posedge clk) begin
        if (rst_n) begin
            if (mem_req && mem_ready && n_acc < 32) begin
                acc_addr[n_acc] = mem_addr;
                acc_cyc[n_acc]  = cyc;
                n_acc = n_acc + 1;
            end
            if (per_valid && per_ready && n_per < 32) begin
                pw[n_per] = per_data;
                n_per = n_per + 1;
            end
            if (done) n_done = n_done + 1;
            if (err)  n_err  = n_err + 1;
        end
        cyc = cyc + 1;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic clear_logs();
        n_acc = 0; n_per = 0; n_done = 0; n_err = 0;
    endtask

    task automatic put(input logic [23:0] a, input logic [31:0] d);
        bmem[a[8:2]] = d;
    endtask

    task automatic finish_up();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    // Raise enable, confirm activity (R1), wait for an end pulse, drop enable.
    task automatic run_walk(input logic [23:0] base);
        clear_logs();
        @(negedge clk);
        base_addr = base;
        en = 1'b1;
        @(negedge clk);
        chk("R1 active after start edge", active, 1'b1);
        for (int i = 0; i < 3000 && (n_done + n_err) == 0; i++) @(negedge clk);
        @(negedge clk);
        en = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R1 reset active", active, 1'b0);
        chk("R1 reset mem_req", mem_req, 1'b0);
        chk("R6 reset per_valid", per_valid, 1'b0);
        chk("R8 reset done", done, 1'b0);
        chk("R9 reset err", err, 1'b0);
    endtask

    task automatic t_basic();
        put(24'h040, {8'd2, 24'h000080});
        put(24'h044, 32'hA1A1_0001);
        put(24'h048, 32'hA1A1_0002);
        put(24'h080, {8'd1, 24'hFFFFFF});
        put(24'h084, 32'hB2B2_0003);
        run_walk(24'h000042);
        chk("R2 read count", n_acc, 5);
        chk("R2 first header addr masked", acc_addr[0], 21'h040);
        chk("R5 payload addr 1", acc_addr[1], 21'h044);
        chk("R5 payload addr 2", acc_addr[2], 21'h048);
        chk("R3 next header addr", acc_addr[3], 21'h080);
        chk("R5 payload addr 3", acc_addr[4], 21'h084);
        chk("R3 payload count", n_per, 3);
        chk("R5 word 0", pw[0], 32'hA1A1_0001);
        chk("R5 word 1", pw[1], 32'hA1A1_0002);
        chk("R5 word 2", pw[2], 32'hB2B2_0003);
        chk("R7 nonzero header spacing", acc_cyc[1] - acc_cyc[0], 16);
        chk("R8 one done pulse", n_done, 1);
        chk("R10 no error", n_err, 0);
        chk("R8 idle after done", active, 1'b0);
    endtask

    task automatic t_zero_len();
        put(24'h100, {8'd0, 24'h000140});
        put(24'h140, {8'd1, 24'hFFFFFF});
        put(24'h144, 32'hC3C3_0004);
        run_walk(24'h000100);
        chk("R4 read count", n_acc, 3);
        chk("R4 second header addr", acc_addr[1], 21'h140);
        chk("R7 zero header spacing", acc_cyc[1] - acc_cyc[0], 12);
        chk("R4 only one word out", n_per, 1);
        chk("R4 word value", pw[0], 32'hC3C3_0004);
        chk("R8 done", n_done, 1);
    endtask

    task automatic t_stalls();
        put(24'h180, {8'd3, 24'h0001C0});
        put(24'h184, 32'h1111_0001);
        put(24'h188, 32'h2222_0002);
        put(24'h18C, 32'h3333_0003);
        put(24'h1C0, {8'd2, 24'hFFFFFF});
        put(24'h1C4, 32'h4444_0004);
        put(24'h1C8, 32'h5555_0005);
        rand_mode = 1'b1;
        run_walk(24'h000180);
        rand_mode = 1'b0;
        chk("R6 word count under stalls", n_per, 5);
        chk("R6 word 0", pw[0], 32'h1111_0001);
        chk("R6 word 1", pw[1], 32'h2222_0002);
        chk("R6 word 2", pw[2], 32'h3333_0003);
        chk("R6 word 3", pw[3], 32'h4444_0004);
        chk("R6 word 4", pw[4], 32'h5555_0005);
        chk("R11 reads under stalls", n_acc, 7);
        chk("R8 done under stalls", n_done, 1);
    endtask

    task automatic t_err_base();
        run_walk(24'h800040);
        chk("R9 no RAM read on bad base", n_acc, 0);
        chk("R9 error pulse", n_err, 1);
        chk("R10 no done on error", n_done, 0);
        chk("R9 idle after error", active, 1'b0);
    endtask

    task automatic t_err_link();
        put(24'h0C0, {8'd1, 24'h800100});
        put(24'h0C4, 32'hD4D4_0005);
        run_walk(24'h0000C0);
        chk("R9 reads stop before bad link", n_acc, 2);
        chk("R9 payload before bad link", n_per, 1);
        chk("R9 error pulse on link", n_err, 1);
        chk("R10 no done on link error", n_done, 0);
    endtask

    task automatic t_edge_busy();
        put(24'h000, {8'd1, 24'hFFFFFF});
        put(24'h004, 32'hE5E5_0006);
        clear_logs();
        mem_stall = 1'b1;
        @(negedge clk);
        base_addr = 24'h000000;
        en = 1'b1;
        repeat (3) @(negedge clk);
        en = 1'b0;
        @(negedge clk);
        en = 1'b1;
        repeat (2) @(negedge clk);
        mem_stall = 1'b0;
        for (int i = 0; i < 200 && n_done == 0; i++) @(negedge clk);
        repeat (20) @(negedge clk);
        chk("R1 busy edge ignored, reads", n_acc, 2);
        chk("R1 busy edge ignored, done", n_done, 1);
        chk("R1 held enable no restart", active, 1'b0);
        en = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        for (int i = 0; i < 128; i++) bmem[i] = 32'h0;
        clear_logs();
        lfsr = 8'h5A;
        rand_mode = 1'b0;
        per_rdy_fixed = 1'b1;
        mem_stall = 1'b0;
        base_addr = '0;
        en = 1'b0;
        rst_n = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_zero_len();
        t_stalls();
        t_err_base();
        t_err_link();
        t_edge_busy();
        finish_up();
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_up();
    end

endmodule